// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Cycle Controller

This block decodes the per-clock command of a single-ported synchronous SRAM with a shared data bus split into byte lanes. On every rising edge it samples three chip selects, a processor address strobe, a controller address strobe, a burst-advance input and the write controls. From these it classifies the cycle as a deselect, the start of a burst, a burst continuation or a burst suspension. It then drives per-lane write strobes into a small behavioural memory, and it produces a drive-enable for the tristate data pins.

The two low address bits run through a wrapping burst sequencer. A strap input selects either the interleaved (XOR) order or the linear (add) order. Read data is flow-through: after each edge, the read data output shows the word at the address captured at that edge, with no further register. Each lane's extra check bit travels as the top bit of that lane and gets no special handling.

Top module: `sram_ft_ctrl`

## Requirements
- R1: A burst starts at an edge when `cs1_n`=0, `cs2`=1 and `cs3_n`=0, and an effective strobe is low. The full external address is loaded, and its two low bits become the burst base with offset 0.
- R2: A strobe seen with any chip-select condition failing is a deselect cycle. It writes nothing, leaves `bus_drive` low, and leaves the controller unselected. With no strobe, an unselected controller stays unselected and makes no access.
- R3: `astb_cpu_n` is ignored while `cs1_n` is high. The cycle is then decoded as if that strobe were inactive.
- R4: A burst started by `astb_cpu_n` is a read in its first cycle, whatever the write inputs are. When both strobes are low, the processor strobe wins.
- R5: A burst started by `astb_ctl_n` (processor strobe inactive) writes `wdata` to the external address in that same cycle if the write inputs request a write. Otherwise it is a read.
- R6: While selected with both strobes inactive, `burst_adv_n`=0 moves to the next burst offset (modulo 4) and `burst_adv_n`=1 keeps the current address. The cycle reads or writes according to the write inputs.
- R7: The low two address bits are base XOR offset when `ilv_order`=1, and (base + offset) mod 4 when `ilv_order`=0. The upper address bits stay fixed during a burst.
- R8: `wr_all_n`=0 writes both lanes, whatever the lane selects are. Otherwise `wr_byte_n`=0 writes each lane whose `lane_sel_n` bit is 0. Lane 0 is bits 8:0 and lane 1 is bits 17:9. With `wr_all_n`=1 and either `wr_byte_n`=1 or all selects high, the cycle is a read.
- R9: After an edge that made a read access, `rdata` equals the stored word at that access's address.
- R10: `bus_drive` is high only when `out_en_n` is 0 and the last edge made a read access that was not the first access after an unselected state. It stays low during write cycles.
- R11: After reset the controller is unselected and `bus_drive` is low.
- R12: After a write, reads that continue or suspend the burst do not drive the bus. Driving resumes only after a new burst read is started by either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | External word address |
| cs1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| astb_cpu_n | input | 1 | Processor address strobe, active low |
| astb_ctl_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Advance burst offset, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Enable per-lane writes, active low |
| lane_sel_n | input | 2 | Per-lane write selects, active low |
| ilv_order | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Output enable, active low, combinational |
| wdata | input | 18 | Write data from the bus |
| rdata | output | 18 | Flow-through read data toward the bus |
| bus_drive | output | 1 | Enable for the bus drivers |

## Verification
On every cycle the assertions check the following:
- A failed chip-select condition or a processor-strobe start never produces lane strobes.
- The global write fires both lanes.
- A write cycle or deselect is followed by an undriven bus.
- A continuation after a write does not drive.
- Reset leaves the bus idle.

The burst orders, flow-through data values, lane masking and first-access masking can only be shown by the bench's scenarios. Those scenarios compare the read data and drive state against a reference model, for directed bursts in both orders and for long randomized command streams.

// File: rtl/sram_ft_pkg.sv
// Shared cycle classification for the flow-through SRAM controller.
package sram_ft_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE,   // unselected, no strobe: no access
        CYC_DESEL,  // strobe with failed chip selects
        CYC_BEGIN,  // new burst from external address
        CYC_CONT,   // advance to next burst offset
        CYC_SUSP    // hold current burst address
    } cyc_kind_t;
endpackage

// File: rtl/sram_cyc_decode.sv
// Cycle decoder: classifies the sampled controls into one cycle kind and
// produces the per-lane write strobes. Assumes all inputs are sampled
// at the same rising edge; purely combinational.
module sram_cyc_decode
    import sram_ft_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_q,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             astb_cpu_n,
    input  logic             astb_ctl_n,
    input  logic             burst_adv_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_sel_n,
    output cyc_kind_t        kind,
    output logic [LANES-1:0] lane_we
);
    logic cpu_eff, strobe, cs_ok, wr_req, is_write;
    logic [LANES-1:0] lane_pick;

    // Strobe qualification and write-request decode.
    always_comb begin
        cpu_eff   = !astb_cpu_n && !cs1_n;
        strobe    = cpu_eff || !astb_ctl_n;
        cs_ok     = !cs1_n && cs2 && !cs3_n;
        wr_req    = !wr_all_n || (!wr_byte_n && (lane_sel_n != '1));
        lane_pick = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_sel_n : '0);
    end

    // Cycle classification and read/write selection.
    always_comb begin
        if (strobe)
            kind = cs_ok ? CYC_BEGIN : CYC_DESEL;
        else if (sel_q)
            kind = burst_adv_n ? CYC_SUSP : CYC_CONT;
        else
            kind = CYC_IDLE;
        case (kind)
            CYC_BEGIN:          is_write = !cpu_eff && wr_req;
            CYC_CONT, CYC_SUSP: is_write = wr_req;
            default:            is_write = 1'b0;
        endcase
        lane_we = is_write ? lane_pick : '0;
    end
endmodule

// File: rtl/sram_burst_seq.sv
// Burst sequencer for the low address bits: keeps the burst base and a
// wrapping offset, and returns the low bits that apply to the current edge.
// Assumes load and step are never both set.
module sram_burst_seq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          ilv_order,
    input  logic [CW-1:0] base_in,
    output logic [CW-1:0] low_now
);
    logic [CW-1:0] base_q, cnt_q, base_d, cnt_d;

    // Next base and offset for this edge.
    always_comb begin
        base_d = load ? base_in : base_q;
        cnt_d  = load ? '0 : (step ? cnt_q + 1'b1 : cnt_q);
        low_now = ilv_order ? (base_d ^ cnt_d) : (base_d + cnt_d);
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/sram_lane_array.sv
// Behavioural storage split into independently written byte lanes.
// Asynchronous read, synchronous write; no reset of contents.
module sram_lane_array #(
    parameter int AW    = 8,
    parameter int LANES = 2,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic [LANES-1:0]    we,
    input  logic [AW-1:0]       waddr,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];
        // Lane write port.
        always_ff @(posedge clk) begin
            if (we[g]) cells[waddr] <= wdata[g*LW +: LW];
        end
        assign rdata[g*LW +: LW] = cells[raddr];
    end
endmodule

// File: rtl/sram_ft_ctrl.sv
// Flow-through SRAM cycle controller top. Registers the access address and
// the drive-mask state; read data flows from storage without an output
// register. Assumes ilv_order is static while a burst is in progress.
module sram_ft_ctrl
    import sram_ft_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 2,
    parameter int LW    = 9,
    parameter int CW    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                cs1_n,
    input  logic                cs2,
    input  logic                cs3_n,
    input  logic                astb_cpu_n,
    input  logic                astb_ctl_n,
    input  logic                burst_adv_n,
    input  logic                wr_all_n,
    input  logic                wr_byte_n,
    input  logic [LANES-1:0]    lane_sel_n,
    input  logic                ilv_order,
    input  logic                out_en_n,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata,
    output logic                bus_drive
);
    localparam int HW = AW - CW;

    cyc_kind_t        kind;
    logic [LANES-1:0] lane_we;
    logic [CW-1:0]    low_now;
    logic [HW-1:0]    hi_q, hi_now;
    logic [AW-1:0]    eff_addr, addr_q;
    logic             sel_q, rd_q, mask_q, hold_q;
    logic             is_begin, access, wr_any;

    sram_cyc_decode #(.LANES(LANES)) u_dec (
        .sel_q(sel_q), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n),
        .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n),
        .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
        .kind(kind), .lane_we(lane_we)
    );

    sram_burst_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(is_begin),
        .step(kind == CYC_CONT), .ilv_order(ilv_order),
        .base_in(addr[CW-1:0]), .low_now(low_now)
    );

    sram_lane_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
        .clk(clk), .we(lane_we), .waddr(eff_addr), .wdata(wdata),
        .raddr(addr_q), .rdata(rdata)
    );

    // Effective address for the access at this edge.
    always_comb begin
        is_begin = (kind == CYC_BEGIN);
        access   = is_begin || (kind == CYC_CONT) || (kind == CYC_SUSP);
        wr_any   = (lane_we != '0);
        hi_now   = is_begin ? addr[AW-1:CW] : hi_q;
        eff_addr = {hi_now, low_now};
    end

    // Selection, access and output-masking state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            hi_q   <= '0;
            addr_q <= '0;
            rd_q   <= 1'b0;
            mask_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (is_begin)             sel_q <= 1'b1;
            else if (kind == CYC_DESEL) sel_q <= 1'b0;
            hi_q   <= hi_now;
            addr_q <= eff_addr;
            rd_q   <= access && !wr_any;
            mask_q <= is_begin && !sel_q;
            if (wr_any)        hold_q <= 1'b1;
            else if (is_begin) hold_q <= 1'b0;
        end
    end

    // Bus drive: read data only, unmasked, with output enable low.
    assign bus_drive = rd_q && !mask_q && !hold_q && !out_en_n;
endmodule

// File: rtl/sram_ft_ctrl_chk.sv
// Protocol checker for the flow-through SRAM controller, bound to the top.
module sram_ft_ctrl_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs1_n,
    input logic             cs2,
    input logic             cs3_n,
    input logic             astb_cpu_n,
    input logic             astb_ctl_n,
    input logic             wr_all_n,
    input logic             bus_drive,
    input logic [LANES-1:0] lane_we
);
    logic strobe, cs_ok;
    assign strobe = (!astb_cpu_n && !cs1_n) || !astb_ctl_n;
    assign cs_ok  = !cs1_n && cs2 && !cs3_n;

    a_r2_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cs_ok) |-> (lane_we == '0));
    a_r2_desel_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cs_ok) |=> !bus_drive);
    a_r4_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!astb_cpu_n && !cs1_n) |-> (lane_we == '0));
    a_r8_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_all_n && lane_we != '0) |-> (lane_we == '1));
    a_r10_write_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |=> !bus_drive);
    a_r12_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lane_we) != '0) && astb_cpu_n && astb_ctl_n) |=> !bus_drive);
    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !bus_drive);
endmodule

bind sram_ft_ctrl sram_ft_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n), .wr_all_n(wr_all_n),
    .bus_drive(bus_drive), .lane_we(lane_we)
);

// File: tb/sram_ft_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ft_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] addr;
    logic cs1_n, cs2, cs3_n, astb_cpu_n, astb_ctl_n, burst_adv_n;
    logic wr_all_n, wr_byte_n, ilv_order, out_en_n;
    logic [1:0] lane_sel_n;
    logic [DW-1:0] wdata, rdata;
    logic bus_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [DW-1:0] m_mem [DEPTH];
    logic m_sel, m_rd, m_mask, m_hold;
    logic [1:0] m_base, m_cnt;
    logic [AW-3:0] m_hi;
    logic [AW-1:0] m_addr;

    always #2.5 clk = ~clk;

    sram_ft_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n),
        .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_sel_n(lane_sel_n), .ilv_order(ilv_order), .out_en_n(out_en_n),
        .wdata(wdata), .rdata(rdata), .bus_drive(bus_drive)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a[1:0], a, ~a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_idle();
        addr = '0; cs1_n = 0; cs2 = 1; cs3_n = 0;
        astb_cpu_n = 1; astb_ctl_n = 1; burst_adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_sel_n = 2'b11;
        out_en_n = 0; wdata = '0;
    endtask

    // Advance the model for the inputs now applied (R1-R8, R12).
    task automatic model_edge();
        bit cpu_eff, strobe, cs_ok, wr_req, begin_c, access, wr;
        logic [1:0] lanes, low;
        cpu_eff = !astb_cpu_n && !cs1_n;
        strobe  = cpu_eff || !astb_ctl_n;
        cs_ok   = !cs1_n && cs2 && !cs3_n;
        wr_req  = !wr_all_n || (!wr_byte_n && lane_sel_n != 2'b11);
        begin_c = 0; access = 0; wr = 0;
        if (strobe && cs_ok) begin
            begin_c = 1; access = 1; wr = !cpu_eff && wr_req;
            m_base = addr[1:0]; m_cnt = 0; m_hi = addr[AW-1:2];
        end else if (!strobe && m_sel) begin
            access = 1; wr = wr_req;
            if (!burst_adv_n) m_cnt = m_cnt + 1;
        end
        low = ilv_order ? (m_base ^ m_cnt) : (m_base + m_cnt);
        m_addr = {m_hi, low};
        m_mask = begin_c && !m_sel;
        if (begin_c) m_sel = 1;
        else if (strobe) m_sel = 0;
        if (wr) begin
            lanes = !wr_all_n ? 2'b11 : ~lane_sel_n;
            if (lanes[0]) m_mem[m_addr][8:0]  = wdata[8:0];
            if (lanes[1]) m_mem[m_addr][17:9] = wdata[17:9];
            m_hold = 1;
        end else if (begin_c) m_hold = 0;
        m_rd = access && !wr;
    endtask

    // One clock with the current inputs, then compare at the falling edge.
    task automatic step(input string tag);
        bit exp_en;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        exp_en = m_rd && !m_mask && !m_hold && !out_en_n;
        chk(bus_drive === exp_en, {tag, " drive (R10)"}, {17'b0, bus_drive}, {17'b0, exp_en});
        if (exp_en)
            chk(rdata === m_mem[m_addr], {tag, " data (R9)"}, rdata, m_mem[m_addr]);
        set_idle();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        set_idle();
        ilv_order = 1;
        rst_n = 0;
        m_sel = 0; m_rd = 0; m_mask = 0; m_hold = 0;
        m_base = 0; m_cnt = 0; m_hi = 0; m_addr = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 'x;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R11: idle after reset
        chk(bus_drive === 1'b0, "R11 reset drive", {17'b0, bus_drive}, '0);
        step("R11");

        // R5: prefill by controller-strobe writes
        for (int a = 0; a < DEPTH; a++) begin
            astb_ctl_n = 0; addr = a[AW-1:0]; wr_all_n = 0; wdata = pat(a[AW-1:0]);
            step("R5");
        end

        // R4: processor strobe with write inputs is a read; R12 cleared
        astb_cpu_n = 0; addr = 8'h10; wr_all_n = 0; wdata = '1;
        step("R4");
        chk(rdata === pat(8'h10), "R4 no write", rdata, pat(8'h10));
        // R4: both strobes low, processor wins
        astb_cpu_n = 0; astb_ctl_n = 0; addr = 8'h11; wr_all_n = 0; wdata = '1;
        step("R4");
        chk(rdata === pat(8'h11), "R4 priority", rdata, pat(8'h11));

        // R2: deselect by cs2 low with controller strobe
        astb_ctl_n = 0; cs2 = 0; addr = 8'h20; wr_all_n = 0; wdata = '1;
        step("R2");
        chk(bus_drive === 1'b0, "R2 deselect drive", {17'b0, bus_drive}, '0);
        // R3: processor strobe with cs1 high ignored: stays unselected
        astb_cpu_n = 0; cs1_n = 1; addr = 8'h30;
        step("R3");
        chk(bus_drive === 1'b0, "R3 ignored strobe", {17'b0, bus_drive}, '0);
        // R2: unselected continuation makes no write
        burst_adv_n = 0; wr_all_n = 0; wdata = '1;
        step("R2");
        // R10: first read after unselected is masked; R6 next offset drives
        astb_cpu_n = 0; addr = 8'h20;
        step("R10");
        chk(bus_drive === 1'b0, "R10 first masked", {17'b0, bus_drive}, '0);
        chk(m_mem[8'h20] === pat(8'h20), "R2 no write", m_mem[8'h20], pat(8'h20));
        burst_adv_n = 0;
        step("R6");
        chk(bus_drive && rdata === pat(8'h21), "R6 continue", rdata, pat(8'h21));
        // R6: suspend holds address
        step("R6");
        chk(rdata === pat(8'h21), "R6 suspend", rdata, pat(8'h21));
        // R10: out_en_n high stops drive
        out_en_n = 1;
        step("R10");

        // R7: interleaved order from base 1: 1,0,3,2,1
        astb_cpu_n = 0; addr = 8'h41;
        step("R7");
        for (int k = 0; k < 4; k++) begin burst_adv_n = 0; step("R7"); end
        chk(rdata === pat(8'h41), "R7 interleaved wrap", rdata, pat(8'h41));
        // R7: linear order from base 3: 3,0,1,2
        ilv_order = 0;
        astb_cpu_n = 0; addr = 8'h53;
        step("R7");
        burst_adv_n = 0; step("R7");
        chk(rdata === pat(8'h50), "R7 linear wrap", rdata, pat(8'h50));
        burst_adv_n = 0; step("R7");
        chk(rdata === pat(8'h51), "R7 linear next", rdata, pat(8'h51));
        ilv_order = 1;

        // R8: lane 0 only via lane selects
        astb_ctl_n = 0; addr = 8'h60; wr_byte_n = 0; lane_sel_n = 2'b10; wdata = '0;
        step("R8");
        // R12: suspended read after write does not drive
        step("R12");
        chk(bus_drive === 1'b0, "R12 hold", {17'b0, bus_drive}, '0);
        // R8: global write overrides all-high selects
        wr_all_n = 0; lane_sel_n = 2'b11; wdata = 18'h2AAAA;
        burst_adv_n = 0;
        step("R8");
        // R8: wr_byte_n high with selects low is a read (still held, R12)
        lane_sel_n = 2'b00; burst_adv_n = 1;
        step("R8");
        astb_ctl_n = 0; addr = 8'h60;
        step("R12");
        chk(rdata === {pat(8'h60)[17:9], 9'h0}, "R8 lane0 only", rdata, {pat(8'h60)[17:9], 9'h0});
        astb_ctl_n = 0; addr = 8'h61;
        step("R8");
        chk(rdata === 18'h2AAAA, "R8 global", rdata, 18'h2AAAA);
        // R1: begin with all selects valid loads full address
        astb_ctl_n = 0; addr = 8'hC7;
        step("R1");
        chk(bus_drive && rdata === pat(8'hC7), "R1 begin", rdata, pat(8'hC7));

        // Randomized streams in both orders
        for (int n = 0; n < 6000; n++) begin
            int r;
            if (n == 3000) begin
                astb_ctl_n = 0; cs3_n = 1; step("R2");
                ilv_order = 0;
            end
            r = $urandom % 16;
            astb_cpu_n = (r < 2) ? 1'b0 : 1'b1;
            astb_ctl_n = (r >= 2 && r < 5) ? 1'b0 : 1'b1;
            cs1_n = ($urandom % 8 == 0);
            cs2 = ($urandom % 8 != 0);
            cs3_n = ($urandom % 8 == 0);
            burst_adv_n = $urandom % 2;
            wr_all_n = ($urandom % 5 != 0);
            wr_byte_n = ($urandom % 3 != 0);
            lane_sel_n = $urandom % 4;
            out_en_n = ($urandom % 6 == 0);
            addr = $urandom % DEPTH;
            wdata = $urandom % (1 << DW);
            step("R6");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule